// File: doc/BRIEF.md
# Programmer-Side Code Memory Read, Program and Verify Sequencer

This block sits on the programmer side of a parallel code-memory programming port. It takes one command at a time: read, program, verify, or set the level of the device reset line. It then drives the device's address and data lines, a divided device clock, the output-enable and program strobes, and two enables. One enable switches the programming voltage and the other raises the supply. Every read-type access is split into two equal halves of a stable address window. In the first half output-enable stays high so the device's sense amplifier precharges. In the second half output-enable goes low and the returned data is captured on the last cycle.

The device clock runs continuously at the system clock divided by a parameter. The block counts rising edges of that clock since the last change of the device reset line. No strobe is issued until a minimum run of edges has elapsed, which lets the reset filter inside the device settle. A verify is a read made with both enables raised, compared against the expected byte supplied with the command. A match gives a one-cycle done pulse. A mismatch raises an error flag and latches the failing address.

Top module: `eprom_rv_seq`

## Requirements
- R1: After reset, busy, done and err are 0, dev_oe_n and dev_pgm_n are 1, vpp_en, vcc_hi and dev_data_oe are 0, and dev_rst_n is 0.
- R2: dev_clk runs freely with a period of CLK_DIV system clocks (default 4) and is high for CLK_DIV/2 of them.
- R3: dev_oe_n and dev_pgm_n stay high until at least PRE_PULSES (default 12) rising edges of dev_clk have occurred since reset or since the last change of dev_rst_n. An edge in the same cycle as the change does not count.
- R4: A read (op 0) keeps dev_oe_n high for 1 + HALF_CYC cycles of busy when the edge count is already met. It then holds dev_oe_n low for HALF_CYC cycles. rd_data takes the value on dev_data_in in the last low cycle, and done pulses for one cycle as busy falls.
- R5: dev_addr stays constant for as long as busy is high.
- R6: A program (op 1) holds vpp_en, vcc_hi and dev_data_oe high throughout, with dev_data_out stable and dev_oe_n high. dev_pgm_n is high for 1 + HALF_CYC cycles, low for PULSE_CYC cycles, then high for HALF_CYC cycles before busy falls with done.
- R7: A verify (op 2) follows the read timing of R4 with vpp_en and vcc_hi high. When the captured byte equals the command's data, done pulses and err stays 0.
- R8: On a verify mismatch, done does not pulse, err goes to 1 and fail_addr takes the command's address. err stays 1 until the next accepted start.
- R9: A start while busy is ignored: the running operation's address and result are unchanged, and no second operation follows.
- R10: A start in the cycle that done is high is accepted, and busy is high in the following cycle.
- R11: A reset-level command (op 3) sets dev_rst_n to wdata bit 0. If the level changes, the edge count restarts and done waits for PRE_PULSES new edges. If the level is unchanged, busy lasts one cycle.
- R12: dev_data_oe is high only while dev_oe_n is high, and dev_oe_n and dev_pgm_n are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Command strobe, taken only while idle |
| op | input | 2 | 0 read, 1 program, 2 verify, 3 set reset level |
| addr | input | AW | Command address |
| wdata | input | DW | Program data, expected verify data, or reset level in bit 0 |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Verify mismatch flag |
| fail_addr | output | AW | Address of the last verify mismatch |
| rd_data | output | DW | Byte captured by the last read or verify |
| dev_clk | output | 1 | Divided device clock |
| dev_rst_n | output | 1 | Device reset level |
| dev_addr | output | AW | Device address |
| dev_data_out | output | DW | Data driven to the device when programming |
| dev_data_oe | output | 1 | Drive enable for dev_data_out |
| dev_data_in | input | DW | Data returned by the device |
| dev_oe_n | output | 1 | Output-enable, active low (high during precharge) |
| dev_pgm_n | output | 1 | Program strobe, active low |
| vpp_en | output | 1 | Programming voltage enable |
| vcc_hi | output | 1 | Raised supply select |

## Verification
The completion of one operation and the acceptance of the next can fall in the same cycle, because done is raised on the edge that returns the block to idle. The bench waits for the sample in which done is high and busy is low, drives start with a new read in that same cycle, and expects busy to be high in the next cycle. It also expects the second read to return its own address's byte. The opposite case is a start raised during an operation. It is judged by checking that the address stayed unchanged, that the first read's byte was returned, and that busy stays low afterwards.

// File: rtl/eprom_rv_seq.sv
module eprom_rv_seq #(
  parameter int AW         = 12,
  parameter int DW         = 8,
  parameter int CLK_DIV    = 4,
  parameter int HALF_CYC   = 3,
  parameter int PULSE_CYC  = 5,
  parameter int PRE_PULSES = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    op,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [AW-1:0] fail_addr,
  output logic [DW-1:0] rd_data,
  output logic          dev_clk,
  output logic          dev_rst_n,
  output logic [AW-1:0] dev_addr,
  output logic [DW-1:0] dev_data_out,
  output logic          dev_data_oe,
  input  logic [DW-1:0] dev_data_in,
  output logic          dev_oe_n,
  output logic          dev_pgm_n,
  output logic          vpp_en,
  output logic          vcc_hi
);

  localparam int MAXC = (HALF_CYC > PULSE_CYC) ? HALF_CYC : PULSE_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam int DIVW = $clog2(CLK_DIV);
  localparam int PW   = $clog2(PRE_PULSES + 1);
  localparam logic [DIVW-1:0] DIV_LAST = DIVW'(CLK_DIV - 1);
  localparam logic [DIVW-1:0] DIV_HALF = DIVW'(CLK_DIV / 2);
  localparam logic [CW-1:0]   HALF_END = CW'(HALF_CYC - 1);
  localparam logic [CW-1:0]   PULS_END = CW'(PULSE_CYC - 1);
  localparam logic [PW-1:0]   PRE_N    = PW'(PRE_PULSES);

  localparam logic [1:0] OP_RD = 2'd0, OP_PG = 2'd1, OP_VF = 2'd2, OP_RL = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_PRE, S_ACT, S_HOLD} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [1:0]    op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wd_q;
  logic          rst_q;
  logic [DIVW-1:0] div_q;
  logic [PW-1:0]   warm;

  wire accept   = start && (st == S_IDLE);
  wire rst_chg  = accept && (op == OP_RL) && (wdata[0] != rst_q);
  wire edge_ev  = (div_q == DIV_LAST);
  wire warm_ok  = (warm >= PRE_N);
  wire act_last = (cnt == ((op_q == OP_PG) ? PULS_END : HALF_END));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 div_q <= '0;
    else if (edge_ev)           div_q <= '0;
    else                        div_q <= div_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 warm <= '0;
    else if (rst_chg)           warm <= '0;
    else if (edge_ev && !warm_ok) warm <= warm + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      op_q      <= OP_RD;
      addr_q    <= '0;
      wd_q      <= '0;
      rst_q     <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      fail_addr <= '0;
      rd_data   <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          op_q   <= op;
          addr_q <= addr;
          wd_q   <= wdata;
          err    <= 1'b0;
          st     <= S_WAIT;
          if (op == OP_RL) rst_q <= wdata[0];
        end
        S_WAIT: if (warm_ok) begin
          cnt <= '0;
          if (op_q == OP_RL) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else st <= S_PRE;
        end
        S_PRE: if (cnt == HALF_END) begin
          st  <= S_ACT;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
        S_ACT: if (act_last) begin
          cnt <= '0;
          if (op_q == OP_PG) st <= S_HOLD;
          else begin
            st      <= S_IDLE;
            rd_data <= dev_data_in;
            if (op_q == OP_VF && dev_data_in != wd_q) begin
              err       <= 1'b1;
              fail_addr <= addr_q;
            end else done <= 1'b1;
          end
        end else cnt <= cnt + 1'b1;
        S_HOLD: if (cnt == HALF_END) begin
          st   <= S_IDLE;
          done <= 1'b1;
        end else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  wire hv = (op_q == OP_PG) || (op_q == OP_VF);

  assign busy         = (st != S_IDLE);
  assign dev_clk      = (div_q < DIV_HALF);
  assign dev_rst_n    = rst_q;
  assign dev_addr     = addr_q;
  assign dev_data_out = wd_q;
  assign dev_data_oe  = busy && (op_q == OP_PG);
  assign dev_oe_n     = !((st == S_ACT) && (op_q != OP_PG));
  assign dev_pgm_n    = !((st == S_ACT) && (op_q == OP_PG));
  assign vpp_en       = busy && hv;
  assign vcc_hi       = busy && hv;

  AST_ADDR_HOLD:   assert property (@(posedge clk) disable iff (!rst_n) (busy && $past(busy)) |-> $stable(dev_addr)); // R5
  AST_WARM_FIRST:  assert property (@(posedge clk) disable iff (!rst_n) (!dev_oe_n || !dev_pgm_n) |-> warm_ok); // R3
  AST_PGM_SUPPLY:  assert property (@(posedge clk) disable iff (!rst_n) !dev_pgm_n |-> (vpp_en && vcc_hi && dev_data_oe)); // R6
  AST_PGM_DATA:    assert property (@(posedge clk) disable iff (!rst_n) (!dev_pgm_n && $past(!dev_pgm_n)) |-> $stable(dev_data_out)); // R6
  AST_DRIVE_EXCL:  assert property (@(posedge clk) disable iff (!rst_n) dev_data_oe |-> dev_oe_n); // R12
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(!dev_oe_n && !dev_pgm_n)); // R12
  AST_DONE_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n) done |-> !err); // R8
  AST_DONE_IDLE:   assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R10
  AST_ERR_HELD:    assert property (@(posedge clk) disable iff (!rst_n) ($past(err) && !$past(start)) |-> err); // R8

endmodule

// File: tb/sim_eprom_rv_seq.sv
`timescale 1ns/1ps
module sim_eprom_rv_seq;
  localparam int AW = 12, DW = 8, DIV = 4, HALF = 3, PULSE = 5, PRE = 12;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] op = 2'd0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic busy, done, err, dev_clk, dev_rst_n, dev_data_oe, dev_oe_n, dev_pgm_n, vpp_en, vcc_hi;
  logic [AW-1:0] fail_addr, dev_addr;
  logic [DW-1:0] rd_data, dev_data_out, dev_data_in;

  always #2 clk = ~clk;

  eprom_rv_seq #(.AW(AW), .DW(DW), .CLK_DIV(DIV), .HALF_CYC(HALF), .PULSE_CYC(PULSE), .PRE_PULSES(PRE)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .addr(addr), .wdata(wdata),
    .busy(busy), .done(done), .err(err), .fail_addr(fail_addr), .rd_data(rd_data),
    .dev_clk(dev_clk), .dev_rst_n(dev_rst_n), .dev_addr(dev_addr), .dev_data_out(dev_data_out),
    .dev_data_oe(dev_data_oe), .dev_data_in(dev_data_in), .dev_oe_n(dev_oe_n),
    .dev_pgm_n(dev_pgm_n), .vpp_en(vpp_en), .vcc_hi(vcc_hi));

  logic [DW-1:0] mem [16];
  assign dev_data_in = !dev_oe_n ? mem[dev_addr[3:0]] : 8'h00;

  always @(negedge clk)
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem[i] <= 8'hA0 + 8'(i);
    end else if (!dev_pgm_n && vpp_en && dev_data_oe) mem[dev_addr[3:0]] <= dev_data_out;

  int n_chk = 0, n_bad = 0;
  logic pclk = 1'b1, prst = 1'b0, pbusy = 1'b0, ppgm = 1'b1, seen = 1'b0, hv_seen = 1'b0;
  logic [AW-1:0] paddr = '0;
  logic [DW-1:0] pdout = '0;
  int rises = 0, pre_c = 0, lo_c = 0, post_c = 0, bcnt = 0;
  int sr = 0, hi = 0, last_per = 0, last_hi = 0;
  int addr_viol = 0, warm_viol = 0, excl_viol = 0, data_viol = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      rises = 0;
    end else begin
      if (dev_rst_n != prst) rises = 0;
      else if (dev_clk && !pclk && rises < 63) rises++;
      if (dev_clk && !pclk) begin last_per = sr; sr = 1; hi = 1; end
      else begin sr++; if (dev_clk) hi++; end
      if (!dev_clk && pclk) last_hi = hi;
      if (busy && !pbusy) begin pre_c = 0; lo_c = 0; post_c = 0; bcnt = 0; seen = 1'b0; hv_seen = 1'b0; end
      if (busy) begin
        bcnt++;
        if (vpp_en || vcc_hi) hv_seen = 1'b1;
        if (!dev_oe_n || !dev_pgm_n) begin lo_c++; seen = 1'b1; end
        else if (!seen) pre_c++;
        else post_c++;
        if (pbusy && dev_addr != paddr) addr_viol++;
      end
      if ((!dev_oe_n || !dev_pgm_n) && rises < PRE) warm_viol++;
      if ((!dev_oe_n && !dev_pgm_n) || (dev_data_oe && !dev_oe_n)) excl_viol++;
      if (!dev_pgm_n && !ppgm && dev_data_out != pdout) data_viol++;
    end
    pclk = dev_clk; prst = dev_rst_n; pbusy = busy; paddr = dev_addr; ppgm = dev_pgm_n; pdout = dev_data_out;
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cmd(logic [1:0] o, logic [AW-1:0] a, logic [DW-1:0] d);
    op = o; addr = a; wdata = d; start = 1'b1;
    step();
    start = 1'b0;
  endtask

  logic got_done, got_err;
  task automatic wait_idle();
    int n = 0;
    while (busy && n < 1000) begin step(); n++; end
    if (busy) begin n_bad++; n_chk++; $display("FAIL wait_idle actual=busy expected=idle"); end
    got_done = done; got_err = err;
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0); chk("R1 done", done, 0); chk("R1 err", err, 0);
    chk("R1 oe_n", dev_oe_n, 1); chk("R1 pgm_n", dev_pgm_n, 1);
    chk("R1 vpp/vcc", {vpp_en, vcc_hi}, 0); chk("R1 data_oe", dev_data_oe, 0);
    chk("R1 dev_rst_n", dev_rst_n, 0);
  endtask

  task automatic t_clock();
    repeat (20) step();
    chk("R2 period", last_per, DIV); chk("R2 high", last_hi, DIV / 2);
  endtask

  task automatic t_early_read();
    cmd(2'd0, 12'h001, 8'h00); wait_idle();
    chk("R3 no early strobe", warm_viol, 0);
    chk("R3 waited", (pre_c > 1 + HALF) ? 1 : 0, 1);
    chk("R3 data", rd_data, 8'hA1);
  endtask

  task automatic t_rst_level();
    cmd(2'd3, '0, 8'h01); wait_idle();
    chk("R11 level", dev_rst_n, 1); chk("R11 done", got_done, 1);
    chk("R11 edges", (rises >= PRE) ? 1 : 0, 1);
    chk("R11 long wait", (bcnt >= PRE * DIV - DIV) ? 1 : 0, 1);
    cmd(2'd3, '0, 8'h01); wait_idle();
    chk("R11 same level quick", bcnt, 1); chk("R11 same done", got_done, 1);
  endtask

  task automatic t_read(logic [AW-1:0] a, logic [DW-1:0] exp);
    cmd(2'd0, a, 8'h00); wait_idle();
    chk("R4 data", rd_data, exp); chk("R4 done", got_done, 1);
    chk("R4 precharge", pre_c, 1 + HALF); chk("R4 sense", lo_c, HALF); chk("R4 tail", post_c, 0);
    chk("R4 no hv", hv_seen, 0); chk("R5 addr", addr_viol, 0);
  endtask

  task automatic t_program(logic [AW-1:0] a, logic [DW-1:0] d);
    cmd(2'd1, a, d); wait_idle();
    chk("R6 done", got_done, 1); chk("R6 setup", pre_c, 1 + HALF);
    chk("R6 pulse", lo_c, PULSE); chk("R6 hold", post_c, HALF);
    chk("R6 hv", hv_seen, 1); chk("R6 data stable", data_viol, 0); chk("R12 excl", excl_viol, 0);
    t_read(a, d);
  endtask

  task automatic t_verify_ok(logic [AW-1:0] a, logic [DW-1:0] d);
    cmd(2'd2, a, d); wait_idle();
    chk("R7 done", got_done, 1); chk("R7 err", got_err, 0);
    chk("R7 hv", hv_seen, 1); chk("R7 sense", lo_c, HALF); chk("R7 data", rd_data, d);
  endtask

  task automatic t_verify_bad(logic [AW-1:0] a, logic [DW-1:0] d);
    cmd(2'd2, a, d); wait_idle();
    chk("R8 no done", got_done, 0); chk("R8 err", got_err, 1); chk("R8 fail_addr", fail_addr, a);
    repeat (3) step();
    chk("R8 err held", err, 1);
    cmd(2'd0, 12'h002, 8'h00);
    chk("R8 err cleared", err, 0);
    wait_idle();
  endtask

  task automatic t_busy_ignore();
    cmd(2'd0, 12'h005, 8'h00);
    repeat (2) step();
    cmd(2'd0, 12'h009, 8'h00);
    wait_idle();
    chk("R9 result", rd_data, 8'hA5); chk("R9 addr", addr_viol, 0);
    repeat (2) step();
    chk("R9 no second op", busy, 0);
  endtask

  task automatic t_back2back();
    cmd(2'd0, 12'h003, 8'h00); wait_idle();
    chk("R10 done seen", got_done, 1);
    cmd(2'd0, 12'h004, 8'h00);
    chk("R10 accepted", busy, 1);
    wait_idle();
    chk("R10 second data", rd_data, 8'hA4);
  endtask

  logic finished = 1'b0;
  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (3) step();
    t_reset();
    rst_n = 1'b1;
    t_clock();
    t_early_read();
    t_rst_level();
    t_read(12'h006, 8'hA6);
    t_program(12'h007, 8'h3C);
    t_verify_ok(12'h007, 8'h3C);
    t_verify_bad(12'h008, 8'h55);
    t_busy_ignore();
    t_back2back();
    chk("R3 overall", warm_viol, 0);
    chk("R12 overall", excl_viol, 0);
    summary();
  end
endmodule